// File: doc/BRIEF.md
# Block-Based DMA Channel

This block is a single DMA channel that carries half-word data between a peripheral data port and system memory in fixed blocks of 64 bytes, which is 32 half-words. The peripheral side and the host side both reach the channel through one small register interface. That interface selects among six registers: a load address, a mode/status word, the half-word data port, a block counter, a read-only current address and a read-only diagnostic word. A 64-entry half-word FIFO sits between the data port and the memory side. Its fill level can be read in the status word.

The memory side is a burst interface. The channel holds `mem_req` high for one whole block and drives the block address and direction. The responder pulses `mem_beat` once for each half-word it moves. In the memory-write direction the channel presents the FIFO head on `mem_wdata`. In the memory-read direction each beat pushes `mem_rdata` into the FIFO. A burst begins only when the FIFO can take part in the whole block without stalling. After each block the current address moves up by 64 and the block counter drops by one.

When the counter reaches zero, the channel can raise an interrupt. It then either stops or reloads from the load address and runs again. A block after which the next address would enter a new 512 KB region stops the channel with a latched error.

Top module: `blkdma_channel`

## Requirements
- R1: After reset the load address, current address, block counter and diagnostic word read 0, the mode/status word reads 0x0000_0400 (only the empty flag, bit 10, set), `irq` is 0 and `mem_req` is 0.
- R2: A write to select 0 stores the load address with bits 5:0 forced to zero. A mode write (select 3) with bit 30 set while the channel is stopped copies the load address into the current address (select 5).
- R3: A write to select 2 pushes the low 16 bits into the FIFO, and a read of select 2 returns the oldest entry in bits 15:0 and removes it. Status bits 7:0 give the fill level, bit 11 is set at 64 entries and bit 10 at 0 entries. A push into a full FIFO is dropped.
- R4: A mode write with bit 31 set empties the FIFO, and bit 31 always reads back as 0.
- R5: With bit 27 set (memory-write direction), a burst starts only when the FIFO holds at least 32 entries. During the burst `mem_we` is 1, `mem_addr` is the current address, and the 32 beats carry the FIFO contents in push order on `mem_wdata`.
- R6: With bit 27 clear (memory-read direction), a burst starts only when the FIFO holds at most 32 entries, and each beat pushes `mem_rdata` into the FIFO.
- R7: Completing a block adds 64 to the current address and subtracts 1 from the block counter (select 4, bits 15:0). `mem_req` stays high until the 32nd beat.
- R8: When the counter reaches zero with bit 29 clear, the enable bit (bit 30) clears and no further burst starts.
- R9: When the counter reaches zero with bit 28 set, the pending flag (bit 8) and `irq` go to 1. With bit 28 clear they stay 0. A mode write with bit 30 clear clears the pending flag.
- R10: When the counter reaches zero with bit 29 set, the current address reloads from the load address, the counter reloads from the last value written to select 4, and the channel stays enabled.
- R11: If a completed block leaves blocks remaining and the next address is a multiple of 2^19, the error flag (bit 9) sets and the enable bit clears. No burst starts while the error flag is set. A mode write with bit 26 set clears it. Reaching zero exactly at the boundary raises no error.
- R12: An enabled channel whose block counter is zero starts no burst.
- R13: The diagnostic word (select 1) has bit 8 set exactly while a burst is in progress, and bits 4:0 give the beats completed within that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register select (0 load, 1 diagnostic, 2 data port, 3 mode/status, 4 block count, 5 current address) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO on select 2) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the current select |
| irq | output | 1 | Terminal-count interrupt (pending flag) |
| mem_req | output | 1 | Block burst in progress |
| mem_we | output | 1 | 1 = write into memory, 0 = read from memory |
| mem_addr | output | 32 | Block start address |
| mem_beat | input | 1 | One half-word moved this cycle |
| mem_wdata | output | 16 | Half-word going to memory |
| mem_rdata | input | 16 | Half-word coming from memory |

## Verification
The bench works at the FIFO thresholds. It holds 31 entries in the memory-write direction and 33 in the memory-read direction. A design that counted its start condition off by one would launch a burst that underruns or overflows the FIFO. The 512 KB rule is tested on both sides: a run that ends on the boundary must finish cleanly, and a run that would continue past it must stop with the error latched and stay stopped when it is re-enabled. A design that compared the wrong address bits would either run past the boundary or flag a false error. Auto-reload and the interrupt are checked from the reloaded address and counter, and from `irq` being cleared by a disabling mode write. Random FIFO traffic, including pushes into a full FIFO, is compared against a queue model so that a dropped-push or pointer-wrap error shows up as corrupted data.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

    localparam int REG_W = 32;
    localparam int HW_W  = 16;

    typedef enum logic [2:0] {
        SEL_LOAD   = 3'd0,
        SEL_DIAG   = 3'd1,
        SEL_PORT   = 3'd2,
        SEL_MODE   = 3'd3,
        SEL_BLOCKS = 3'd4,
        SEL_CUR    = 3'd5
    } reg_sel_e;

    // mode word control bits
    localparam int MB_FLUSH  = 31;
    localparam int MB_RUN    = 30;
    localparam int MB_RELOAD = 29;
    localparam int MB_TCIRQ  = 28;
    localparam int MB_TOMEM  = 27;
    localparam int MB_ERRCLR = 26;

    // mode word status bits
    localparam int SB_FULL  = 11;
    localparam int SB_EMPTY = 10;
    localparam int SB_ERR   = 9;
    localparam int SB_PEND  = 8;
    localparam int SB_DIAG_BUSY = 8;

endpackage

// File: rtl/blkdma_fifo.sv
module blkdma_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [FW-1:0] fill,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [FW-1:0] fill;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [W-1:0] store [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push && (q.fill != FW'(DEPTH));
        do_pop  = pop && (q.fill != '0);
        if (clr) begin
            d = '0;
        end else begin
            if (do_push) d.wp = (q.wp == PW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
            if (do_pop)  d.rp = (q.rp == PW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
            if (do_push && !do_pop) d.fill = q.fill + 1'b1;
            if (do_pop && !do_push) d.fill = q.fill - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) store[q.wp] <= din;
    end

    assign dout  = store[q.rp];
    assign fill  = q.fill;
    assign full  = (q.fill == FW'(DEPTH));
    assign empty = (q.fill == '0);

    assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FW'(DEPTH));
    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (fill == FW'(DEPTH)));
    assert_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);

endmodule

// File: rtl/blkdma_engine.sv
module blkdma_engine
    import blkdma_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CW         = 16,
    parameter int DEPTH      = 64,
    parameter int BLK_HW     = 32,
    parameter int BOUND_BITS = 19,
    localparam int FW        = $clog2(DEPTH + 1),
    localparam int BW        = $clog2(BLK_HW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic [FW-1:0]    fill,
    input  logic             mem_beat,
    output logic [AW-1:0]    load_addr,
    output logic [AW-1:0]    cur_addr,
    output logic [CW-1:0]    blocks_left,
    output logic             run,
    output logic             reload,
    output logic             tcirq,
    output logic             tomem,
    output logic             err,
    output logic             pend,
    output logic             busy,
    output logic [BW-1:0]    beat,
    output logic             flush,
    output logic             mem_push,
    output logic             mem_pop
);

    localparam int BLK_BYTES = 2 * BLK_HW;
    localparam int SH        = $clog2(BLK_BYTES);

    typedef struct packed {
        logic [AW-1:0] load;
        logic [AW-1:0] cur;
        logic [CW-1:0] left;
        logic [CW-1:0] reload_cnt;
        logic          run;
        logic          reload;
        logic          tcirq;
        logic          tomem;
        logic          err;
        logic          pend;
        logic          busy;
        logic [BW-1:0] beat;
    } eng_st_t;

    eng_st_t q, d;
    logic          sel_mode, start, last_beat;
    logic [AW-1:0] next_addr;
    logic [CW-1:0] left_m1;
    logic          unused_bits;

    assign unused_bits = ^wr_data[SH-1:0];

    always_comb begin
        d         = q;
        sel_mode  = wr_en && (wr_sel == SEL_MODE);
        next_addr = q.cur + AW'(BLK_BYTES);
        left_m1   = q.left - 1'b1;

        if (wr_en && (wr_sel == SEL_LOAD)) begin
            d.load = {wr_data[AW-1:SH], {SH{1'b0}}};
        end
        if (wr_en && (wr_sel == SEL_BLOCKS)) begin
            d.left       = wr_data[CW-1:0];
            d.reload_cnt = wr_data[CW-1:0];
        end
        if (sel_mode) begin
            d.run    = wr_data[MB_RUN];
            d.reload = wr_data[MB_RELOAD];
            d.tcirq  = wr_data[MB_TCIRQ];
            d.tomem  = wr_data[MB_TOMEM];
            if (wr_data[MB_ERRCLR]) d.err = 1'b0;
            if (!wr_data[MB_RUN])   d.pend = 1'b0;
            if (wr_data[MB_RUN] && !q.run) d.cur = q.load;
        end

        start = !q.busy && q.run && !q.err && (q.left != '0) &&
                (q.tomem ? (fill >= FW'(BLK_HW)) : (fill <= FW'(DEPTH - BLK_HW)));
        last_beat = q.busy && mem_beat && (q.beat == BW'(BLK_HW - 1));

        if (start) begin
            d.busy = 1'b1;
            d.beat = '0;
        end
        if (q.busy && mem_beat) d.beat = q.beat + 1'b1;

        if (last_beat) begin
            d.busy = 1'b0;
            d.beat = '0;
            if (left_m1 == '0) begin
                if (q.tcirq) d.pend = 1'b1;
                if (q.reload) begin
                    d.cur  = q.load;
                    d.left = q.reload_cnt;
                end else begin
                    d.cur  = next_addr;
                    d.left = '0;
                    d.run  = 1'b0;
                end
            end else begin
                d.cur  = next_addr;
                d.left = left_m1;
                if (next_addr[BOUND_BITS-1:0] == '0) begin
                    d.err = 1'b1;
                    d.run = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign load_addr   = q.load;
    assign cur_addr    = q.cur;
    assign blocks_left = q.left;
    assign run         = q.run;
    assign reload      = q.reload;
    assign tcirq       = q.tcirq;
    assign tomem       = q.tomem;
    assign err         = q.err;
    assign pend        = q.pend;
    assign busy        = q.busy;
    assign beat        = q.beat;
    assign flush       = sel_mode && wr_data[MB_FLUSH];
    assign mem_push    = q.busy && mem_beat && !q.tomem;
    assign mem_pop     = q.busy && mem_beat && q.tomem;

    assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_addr[SH-1:0] == '0) && (load_addr[SH-1:0] == '0));
    assert_tomem_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(tomem)) |-> ($past(fill) >= FW'(BLK_HW)));
    assert_frommem_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !$past(tomem)) |-> ($past(fill) <= FW'(DEPTH - BLK_HW)));
    assert_burst_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(mem_beat));
    assert_pend_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(tcirq));
    assert_err_halts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !run);
    assert_err_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !$rose(busy));

endmodule

// File: rtl/blkdma_channel.sv
module blkdma_channel
    import blkdma_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CW         = 16,
    parameter int DEPTH      = 64,
    parameter int BLK_HW     = 32,
    parameter int BOUND_BITS = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_beat,
    output logic [HW_W-1:0]  mem_wdata,
    input  logic [HW_W-1:0]  mem_rdata
);

    localparam int FW = $clog2(DEPTH + 1);
    localparam int BW = $clog2(BLK_HW);

    logic [AW-1:0]   load_addr, cur_addr;
    logic [CW-1:0]   blocks_left;
    logic            run, reload, tcirq, tomem, err, pend, busy;
    logic [BW-1:0]   beat;
    logic            flush, mem_push, mem_pop;
    logic [FW-1:0]   fill;
    logic            full, empty;
    logic [HW_W-1:0] fifo_dout, fifo_din;
    logic            fifo_push, fifo_pop, port_sel;

    assign port_sel  = (reg_sel == SEL_PORT);
    assign fifo_push = mem_push || (reg_wr && port_sel);
    assign fifo_din  = mem_push ? mem_rdata : reg_wdata[HW_W-1:0];
    assign fifo_pop  = mem_pop || (reg_rd && port_sel);

    blkdma_fifo #(.DEPTH(DEPTH), .W(HW_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush),
        .push  (fifo_push),
        .din   (fifo_din),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .fill  (fill),
        .full  (full),
        .empty (empty)
    );

    blkdma_engine #(
        .AW(AW), .CW(CW), .DEPTH(DEPTH), .BLK_HW(BLK_HW), .BOUND_BITS(BOUND_BITS)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr),
        .wr_sel      (reg_sel),
        .wr_data     (reg_wdata),
        .fill        (fill),
        .mem_beat    (mem_beat),
        .load_addr   (load_addr),
        .cur_addr    (cur_addr),
        .blocks_left (blocks_left),
        .run         (run),
        .reload      (reload),
        .tcirq       (tcirq),
        .tomem       (tomem),
        .err         (err),
        .pend        (pend),
        .busy        (busy),
        .beat        (beat),
        .flush       (flush),
        .mem_push    (mem_push),
        .mem_pop     (mem_pop)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_LOAD:   reg_rdata[AW-1:0] = load_addr;
            SEL_DIAG: begin
                reg_rdata[BW-1:0]         = beat;
                reg_rdata[SB_DIAG_BUSY]   = busy;
            end
            SEL_PORT:   reg_rdata[HW_W-1:0] = fifo_dout;
            SEL_MODE: begin
                reg_rdata[MB_RUN]    = run;
                reg_rdata[MB_RELOAD] = reload;
                reg_rdata[MB_TCIRQ]  = tcirq;
                reg_rdata[MB_TOMEM]  = tomem;
                reg_rdata[SB_FULL]   = full;
                reg_rdata[SB_EMPTY]  = empty;
                reg_rdata[SB_ERR]    = err;
                reg_rdata[SB_PEND]   = pend;
                reg_rdata[7:0]       = 8'(fill);
            end
            SEL_BLOCKS: reg_rdata[CW-1:0] = blocks_left;
            SEL_CUR:    reg_rdata[AW-1:0] = cur_addr;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq       = pend;
    assign mem_req   = busy;
    assign mem_we    = tomem;
    assign mem_addr  = cur_addr;
    assign mem_wdata = fifo_dout;

    assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mem_req));

endmodule

// File: tb/blkdma_channel_bench.sv
module blkdma_channel_bench;

    localparam logic [31:0] M_FLUSH  = 32'h8000_0000;
    localparam logic [31:0] M_RUN    = 32'h4000_0000;
    localparam logic [31:0] M_RELOAD = 32'h2000_0000;
    localparam logic [31:0] M_TCIRQ  = 32'h1000_0000;
    localparam logic [31:0] M_TOMEM  = 32'h0800_0000;
    localparam logic [31:0] M_ERRCLR = 32'h0400_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, mem_req, mem_we, mem_beat = 1'b0;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata = '0;

    int n_checks = 0, n_errs = 0;
    int rsp_cnt = 0, n_bursts = 0, n_wlog = 0;
    logic [31:0] burst_addr [64];
    logic        burst_we [64];
    logic [15:0] wlog [128];
    logic [15:0] exp_w [128];
    logic [15:0] model [$];

    always #2 clk = ~clk;

    blkdma_channel u_blkdma_channel (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_beat(mem_beat),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] rd_pat(logic [31:0] a, int idx);
        return 16'(a >> 6) ^ 16'(idx * 16'h0b35) ^ 16'hc3a1;
    endfunction

    // behavioural memory responder
    always @(negedge clk) begin
        if (!mem_req) begin
            mem_beat = 1'b0;
            rsp_cnt  = 0;
        end else if (rsp_cnt < 32 && $urandom_range(0, 3) != 0) begin
            if (rsp_cnt == 0 && n_bursts < 64) begin
                burst_addr[n_bursts] = mem_addr;
                burst_we[n_bursts]   = mem_we;
                n_bursts++;
            end
            mem_beat = 1'b1;
            if (mem_we) begin
                if (n_wlog < 128) wlog[n_wlog] = mem_wdata;
                n_wlog++;
            end else begin
                mem_rdata = rd_pat(mem_addr, rsp_cnt);
            end
            rsp_cnt++;
        end else begin
            mem_beat = 1'b0;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [2:0] sel, logic [31:0] data);
        @(negedge clk);
        reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_peek(logic [2:0] sel, output logic [31:0] data);
        @(negedge clk);
        reg_sel = sel;
        #1 data = reg_rdata;
    endtask

    task automatic reg_pop(output logic [15:0] data);
        @(negedge clk);
        reg_sel = 3'd2; reg_rd = 1'b1;
        #1 data = reg_rdata[15:0];
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_bursts(int n);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (n_bursts >= n && !mem_req) break;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_checks++; n_errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [15:0] h;
        int b0;
        void'($urandom(32'h1d5a));
        idle(4);
        rst_n = 1'b1;

        // R1 reset state
        reg_peek(3'd3, v); check("R1 mode", v, 32'h0000_0400);
        reg_peek(3'd0, v); check("R1 load", v, 0);
        reg_peek(3'd5, v); check("R1 cur", v, 0);
        reg_peek(3'd4, v); check("R1 blocks", v, 0);
        reg_peek(3'd1, v); check("R1 diag", v, 0);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 mem_req", {31'b0, mem_req}, 0);

        // R2 load address alignment
        reg_write(3'd0, 32'h1234_5678);
        reg_peek(3'd0, v); check("R2 load aligned", v, 32'h1234_5640);

        // R3 random FIFO traffic against a queue model (channel stopped)
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 2) != 0) begin
                h = 16'($urandom);
                reg_write(3'd2, {16'h0, h});
                if (model.size() < 64) model.push_back(h);
            end else if (model.size() > 0) begin
                reg_pop(h);
                check("R3 pop data", {16'h0, h}, {16'h0, model.pop_front()});
            end
        end
        reg_peek(3'd3, v); check("R3 fill", {24'h0, v[7:0]}, model.size());
        while (model.size() < 64) begin
            h = 16'($urandom);
            reg_write(3'd2, {16'h0, h});
            model.push_back(h);
        end
        reg_write(3'd2, 32'h0000_dead);
        reg_peek(3'd3, v); check("R3 full", v, 32'h0000_0840);
        for (int i = 0; i < 64; i++) begin
            reg_pop(h);
            check("R3 drain", {16'h0, h}, {16'h0, model.pop_front()});
        end
        reg_peek(3'd3, v); check("R3 empty", v, 32'h0000_0400);

        // R4 flush
        for (int i = 0; i < 5; i++) reg_write(3'd2, i);
        reg_write(3'd3, M_FLUSH);
        reg_peek(3'd3, v); check("R4 flush", v, 32'h0000_0400);

        // R5 memory-write direction, two blocks, interrupt enabled
        reg_write(3'd0, 32'h0010_0000);
        reg_write(3'd4, 2);
        reg_write(3'd3, M_RUN | M_TCIRQ | M_TOMEM);
        reg_peek(3'd5, v); check("R2 cur copied", v, 32'h0010_0000);
        b0 = n_bursts;
        for (int i = 0; i < 31; i++) begin
            exp_w[i] = 16'($urandom);
            reg_write(3'd2, {16'h0, exp_w[i]});
        end
        idle(10);
        check("R5 no start at 31", {31'b0, mem_req}, 0);
        reg_peek(3'd1, v); check("R13 diag idle", v, 0);
        exp_w[31] = 16'($urandom);
        reg_write(3'd2, {16'h0, exp_w[31]});
        for (int i = 0; i < 20 && !mem_req; i++) @(negedge clk);
        reg_peek(3'd1, v); check("R13 diag busy", {31'b0, v[8]}, 1);
        wait_bursts(b0 + 1);
        reg_peek(3'd4, v); check("R7 blocks-1", v, 1);
        reg_peek(3'd5, v); check("R7 cur+64", v, 32'h0010_0040);
        for (int i = 32; i < 64; i++) begin
            exp_w[i] = 16'($urandom);
            reg_write(3'd2, {16'h0, exp_w[i]});
        end
        wait_bursts(b0 + 2);
        check("R5 beats", n_wlog, 64);
        for (int i = 0; i < 64; i++) check("R5 data", {16'h0, wlog[i]}, {16'h0, exp_w[i]});
        check("R5 addr0", burst_addr[b0], 32'h0010_0000);
        check("R5 addr1", burst_addr[b0 + 1], 32'h0010_0040);
        check("R5 dir", {31'b0, burst_we[b0]}, 1);
        reg_peek(3'd3, v); check("R8 R9 status", v, 32'h1800_0500);
        check("R9 irq", {31'b0, irq}, 1);
        for (int i = 0; i < 32; i++) reg_write(3'd2, i);
        idle(20);
        check("R8 stopped", n_bursts, b0 + 2);
        reg_write(3'd3, M_FLUSH);
        check("R9 irq cleared", {31'b0, irq}, 0);
        reg_peek(3'd3, v); check("R4 R9 after", v, 32'h0000_0400);

        // R6 memory-read direction, start gated at 33 entries
        for (int i = 0; i < 33; i++) begin
            exp_w[i] = 16'($urandom);
            reg_write(3'd2, {16'h0, exp_w[i]});
        end
        reg_write(3'd0, 32'h0020_0000);
        reg_write(3'd4, 1);
        b0 = n_bursts;
        reg_write(3'd3, M_RUN);
        idle(10);
        check("R6 no start at 33", n_bursts, b0);
        reg_pop(h); check("R3 head", {16'h0, h}, {16'h0, exp_w[0]});
        wait_bursts(b0 + 1);
        check("R6 addr", burst_addr[b0], 32'h0020_0000);
        check("R6 dir", {31'b0, burst_we[b0]}, 0);
        for (int i = 1; i < 33; i++) begin
            reg_pop(h); check("R6 old data", {16'h0, h}, {16'h0, exp_w[i]});
        end
        for (int i = 0; i < 32; i++) begin
            reg_pop(h); check("R6 mem data", {16'h0, h}, {16'h0, rd_pat(32'h0020_0000, i)});
        end
        reg_peek(3'd3, v); check("R8 R9 no irq", v, 32'h0000_0400);
        check("R9 irq off", {31'b0, irq}, 0);

        // R6 random single-block reads
        for (int r = 0; r < 4; r++) begin
            logic [31:0] a;
            a = $urandom & 32'h03FF_FFC0;
            reg_write(3'd0, a);
            reg_write(3'd4, 1);
            b0 = n_bursts;
            reg_write(3'd3, M_RUN);
            wait_bursts(b0 + 1);
            check("R6 rnd addr", burst_addr[b0], a);
            for (int i = 0; i < 32; i++) begin
                reg_pop(h); check("R6 rnd data", {16'h0, h}, {16'h0, rd_pat(a, i)});
            end
        end

        // R10 auto-reload
        reg_write(3'd0, 32'h0030_0000);
        reg_write(3'd4, 2);
        b0 = n_bursts;
        reg_write(3'd3, M_RUN | M_RELOAD | M_TCIRQ);
        wait_bursts(b0 + 2);
        idle(10);
        check("R10 two bursts", n_bursts, b0 + 2);
        check("R10 addr1", burst_addr[b0 + 1], 32'h0030_0040);
        reg_peek(3'd5, v); check("R10 cur reload", v, 32'h0030_0000);
        reg_peek(3'd4, v); check("R10 cnt reload", v, 2);
        reg_peek(3'd3, v); check("R10 R9 status", v, 32'h7000_0940);
        for (int i = 0; i < 32; i++) begin
            reg_pop(h); check("R10 data", {16'h0, h}, {16'h0, rd_pat(32'h0030_0000, i)});
        end
        wait_bursts(b0 + 3);
        check("R10 restart addr", burst_addr[b0 + 2], 32'h0030_0000);
        reg_write(3'd3, M_FLUSH);
        check("R9 irq clr", {31'b0, irq}, 0);

        // R11 run ending exactly on the boundary: no error
        reg_write(3'd0, 32'h0007_FF80);
        reg_write(3'd4, 2);
        b0 = n_bursts;
        reg_write(3'd3, M_RUN);
        wait_bursts(b0 + 2);
        idle(5);
        reg_peek(3'd3, v); check("R11 exact end", v, 32'h0000_0840);
        reg_write(3'd3, M_FLUSH);

        // R11 crossing with blocks remaining
        reg_write(3'd4, 5);
        b0 = n_bursts;
        reg_write(3'd3, M_RUN);
        wait_bursts(b0 + 2);
        idle(10);
        check("R11 halted", n_bursts, b0 + 2);
        reg_peek(3'd3, v); check("R11 err", v, 32'h0000_0A40);
        reg_peek(3'd5, v); check("R11 cur", v, 32'h0008_0000);
        reg_peek(3'd4, v); check("R11 left", v, 3);
        reg_write(3'd3, M_FLUSH);
        reg_peek(3'd3, v); check("R11 err sticky", v, 32'h0000_0600);
        reg_write(3'd3, M_RUN);
        idle(20);
        check("R11 blocked", n_bursts, b0 + 2);
        reg_write(3'd3, M_ERRCLR);
        reg_peek(3'd3, v); check("R11 cleared", v, 32'h0000_0400);

        // R12 zero block count
        reg_write(3'd4, 0);
        b0 = n_bursts;
        reg_write(3'd3, M_RUN);
        idle(20);
        check("R12 no burst", n_bursts, b0);
        check("R12 mem_req", {31'b0, mem_req}, 0);
        reg_write(3'd3, 0);

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule